// File: doc/BRIEF.md
# Port change wake-up and interrupt unit

This block watches a parallel input port and reports when any pin leaves the value that software last read. A software read of the port stores the synchronised pin values as a reference and arms the comparison. From then on, any difference between the pins and that reference sets a sticky change flag. The flag stays set until software clears it.

While the core sleeps, the flag and the source enable together raise a wake request. This request is combinational, so it still works with the core clock stopped. The unit also chooses where execution resumes. If interrupts are globally enabled, the next program counter is the fixed interrupt vector (0x3FE by default). If they are globally disabled, the core continues at the instruction after the sleep instruction. When the core is awake, the same detection raises an interrupt request if the source enable and the global enable are both set.

Software must disable the watchdog before sleeping in this mode, so that only a port change ends the sleep. The watchdog sits outside this block.

Top module: `port_wake_unit`

## Requirements
- R1: After reset, the change flag, wake request, interrupt request and vector select are all 0, and the comparison is disarmed.
- R2: Each pin passes through a two-flop synchroniser. After a pin changes, the flag is still 0 after the second rising edge and is 1 after the third rising edge, provided the comparison is armed.
- R3: Before the first port read after reset, no pin activity sets the change flag.
- R4: A port read (`port_rd_i` high for one cycle) stores the synchronised pins as the reference and arms the comparison. Pins that equal the reference leave the flag at 0. A difference in any single bit, including bit 0 and bit 7, sets the flag.
- R5: The flag is sticky until `flag_clr_i` is pulsed. Clear has priority in that cycle. If the mismatch persists, the flag sets again on the next edge.
- R6: `wake_req_o` is 1 exactly when the flag, `chg_en_i` and `sleep_i` are all 1. It follows those inputs combinationally, with no clock edge needed.
- R7: When the flag, `chg_en_i` and `gie_i` are all 1, `irq_req_o` and `pc_sel_o` are 1 and `next_pc_o` equals the vector 0x3FE.
- R8: With `gie_i` at 0, a change during sleep raises `wake_req_o`. In that case `pc_sel_o` is 0, `irq_req_o` is 0 and `next_pc_o` equals `pc_next_i`.
- R9: With `chg_en_i` at 0, neither a wake request nor an interrupt request is raised, but the flag still records the change.
- R10: A second read replaces the reference. Pins equal to the new reference do not set the flag, and a return to the old value does set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous port pins |
| port_rd_i | input | 1 | Software port read; stores the reference and arms the comparison |
| flag_clr_i | input | 1 | Software clear of the change flag |
| chg_en_i | input | 1 | Change source enable (interrupt-mask bit 1) |
| gie_i | input | 1 | Global interrupt enable |
| sleep_i | input | 1 | Core is in sleep |
| pc_next_i | input | 10 | Address of the instruction after the current one |
| change_flag_o | output | 1 | Sticky change flag |
| wake_req_o | output | 1 | Combinational wake request |
| irq_req_o | output | 1 | Interrupt request |
| pc_sel_o | output | 1 | 1 selects the vector, 0 the following instruction |
| next_pc_o | output | 10 | Resume address |

## Verification
The checker watches the following on every cycle:
- the flag stays set until cleared;
- a clear takes effect;
- the flag cannot rise while the comparison is disarmed;
- a cleared enable suppresses both requests;
- the resume address always matches the select, and the vector is never chosen with interrupts disabled.

Only the directed scenarios can show:
- the exact three-edge latency through the synchroniser;
- that the reference really is the value present at the read;
- that re-arming with a second read moves the reference;
- the combinational response of the wake request with no clock edge.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
    localparam int unsigned PWU_PORT_W = 8;
    localparam int unsigned PWU_PC_W   = 10;
    localparam int unsigned PWU_SYNC_N = 2;
    localparam logic [PWU_PC_W-1:0] PWU_VECTOR = 10'h3FE;

    typedef enum logic {
        SEL_FOLLOW = 1'b0,
        SEL_VECTOR = 1'b1
    } pc_sel_e;
endpackage

// File: rtl/pwu_sync.sv
module pwu_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q.stg[LAST];
endmodule

// File: rtl/pwu_detect.sv
module pwu_detect #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_s_i,
    input  logic         rd_i,
    input  logic         clr_i,
    output logic         armed_o,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] snap;
        logic         armed;
        logic         flag;
    } det_t;

    det_t st_d, st_q;
    logic differ;

    always_comb begin
        st_d   = st_q;
        differ = st_q.armed && !rd_i && (pin_s_i != st_q.snap);
        if (rd_i) begin
            st_d.snap  = pin_s_i;
            st_d.armed = 1'b1;
        end
        if (clr_i)       st_d.flag = 1'b0;
        else if (differ) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
    assign flag_o  = st_q.flag;
endmodule

// File: rtl/pwu_exit.sv
module pwu_exit
    import pwu_pkg::*;
#(
    parameter int unsigned         PC_W   = 10,
    parameter logic [PC_W-1:0]     VECTOR = '1
) (
    input  logic            flag_i,
    input  logic            en_i,
    input  logic            gie_i,
    input  logic            sleep_i,
    input  logic [PC_W-1:0] pc_next_i,
    output logic            wake_o,
    output logic            irq_o,
    output pc_sel_e         sel_o,
    output logic [PC_W-1:0] next_pc_o
);
    logic live;

    always_comb begin
        live      = flag_i && en_i;
        wake_o    = live && sleep_i;
        irq_o     = live && gie_i;
        sel_o     = irq_o ? SEL_VECTOR : SEL_FOLLOW;
        next_pc_o = (sel_o == SEL_VECTOR) ? VECTOR : pc_next_i;
    end
endmodule

// File: rtl/port_wake_unit.sv
module port_wake_unit
    import pwu_pkg::*;
#(
    parameter int unsigned     PORT_W = PWU_PORT_W,
    parameter int unsigned     PC_W   = PWU_PC_W,
    parameter int unsigned     SYNC_N = PWU_SYNC_N,
    parameter logic [PC_W-1:0] VECTOR = PWU_VECTOR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic              port_rd_i,
    input  logic              flag_clr_i,
    input  logic              chg_en_i,
    input  logic              gie_i,
    input  logic              sleep_i,
    input  logic [PC_W-1:0]   pc_next_i,
    output logic              change_flag_o,
    output logic              wake_req_o,
    output logic              irq_req_o,
    output logic              pc_sel_o,
    output logic [PC_W-1:0]   next_pc_o
);
    logic [PORT_W-1:0] pin_s;
    logic              armed;
    pc_sel_e           sel;

    pwu_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    pwu_detect #(.W(PORT_W)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s_i (pin_s),
        .rd_i    (port_rd_i),
        .clr_i   (flag_clr_i),
        .armed_o (armed),
        .flag_o  (change_flag_o)
    );

    pwu_exit #(.PC_W(PC_W), .VECTOR(VECTOR)) u_exit (
        .flag_i    (change_flag_o),
        .en_i      (chg_en_i),
        .gie_i     (gie_i),
        .sleep_i   (sleep_i),
        .pc_next_i (pc_next_i),
        .wake_o    (wake_req_o),
        .irq_o     (irq_req_o),
        .sel_o     (sel),
        .next_pc_o (next_pc_o)
    );

    assign pc_sel_o = (sel == SEL_VECTOR);
endmodule

// File: rtl/pwu_chk.sv
module pwu_chk #(
    parameter int unsigned     PC_W   = 10,
    parameter logic [PC_W-1:0] VECTOR = '1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            armed,
    input logic            flag_clr_i,
    input logic            chg_en_i,
    input logic            gie_i,
    input logic [PC_W-1:0] pc_next_i,
    input logic            change_flag_o,
    input logic            wake_req_o,
    input logic            irq_req_o,
    input logic            pc_sel_o,
    input logic [PC_W-1:0] next_pc_o
);
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (change_flag_o && !flag_clr_i) |=> change_flag_o);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_i |=> !change_flag_o);

    // R3
    no_unarmed_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(change_flag_o) |-> $past(armed));

    // R9
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en_i |-> (!wake_req_o && !irq_req_o));

    // R7
    vector_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_o |-> (next_pc_o == VECTOR));

    // R8
    follow_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_sel_o |-> (next_pc_o == pc_next_i));

    // R8
    no_vector_gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> !pc_sel_o);
endmodule

bind port_wake_unit pwu_chk #(.PC_W(PC_W), .VECTOR(VECTOR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .armed         (armed),
    .flag_clr_i    (flag_clr_i),
    .chg_en_i      (chg_en_i),
    .gie_i         (gie_i),
    .pc_next_i     (pc_next_i),
    .change_flag_o (change_flag_o),
    .wake_req_o    (wake_req_o),
    .irq_req_o     (irq_req_o),
    .pc_sel_o      (pc_sel_o),
    .next_pc_o     (next_pc_o)
);

// File: tb/port_wake_unit_test.sv
module port_wake_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0;
    logic       port_rd_i = 1'b0;
    logic       flag_clr_i = 1'b0;
    logic       chg_en_i = 1'b0;
    logic       gie_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic [9:0] pc_next_i = 10'h123;
    logic       change_flag_o, wake_req_o, irq_req_o, pc_sel_o;
    logic [9:0] next_pc_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    port_wake_unit uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_i         (pin_i),
        .port_rd_i     (port_rd_i),
        .flag_clr_i    (flag_clr_i),
        .chg_en_i      (chg_en_i),
        .gie_i         (gie_i),
        .sleep_i       (sleep_i),
        .pc_next_i     (pc_next_i),
        .change_flag_o (change_flag_o),
        .wake_req_o    (wake_req_o),
        .irq_req_o     (irq_req_o),
        .pc_sel_o      (pc_sel_o),
        .next_pc_o     (next_pc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_i = '0; port_rd_i = 0; flag_clr_i = 0;
        chg_en_i = 0; gie_i = 0; sleep_i = 0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic set_pins(input logic [7:0] v);
        pin_i = v;
        cycles(4);
    endtask

    task automatic do_read();
        port_rd_i = 1'b1;
        cycles(1);
        port_rd_i = 1'b0;
        cycles(1);
    endtask

    task automatic do_clear();
        flag_clr_i = 1'b1;
        cycles(1);
        flag_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 flag", change_flag_o, 0);
        chk("R1 wake", wake_req_o, 0);
        chk("R1 irq", irq_req_o, 0);
        chk("R1 sel", pc_sel_o, 0);
    endtask

    task automatic t_unarmed();
        do_reset();
        chg_en_i = 1; gie_i = 1;
        set_pins(8'hFF);
        set_pins(8'h3C);
        chk("R3 flag unarmed", change_flag_o, 0);
    endtask

    task automatic t_latency();
        do_reset();
        set_pins(8'h00);
        do_read();
        pin_i = 8'h10;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R2 flag after 2 edges", change_flag_o, 0);
        @(posedge clk); @(negedge clk);
        chk("R2 flag after 3 edges", change_flag_o, 1);
    endtask

    task automatic t_compare();
        do_reset();
        set_pins(8'hA5);
        do_read();
        cycles(4);
        chk("R4 equal pins no flag", change_flag_o, 0);
        set_pins(8'hA4);
        chk("R4 bit0 diff", change_flag_o, 1);
        set_pins(8'hA5);
        do_clear();
        cycles(2);
        chk("R4 back equal after clear", change_flag_o, 0);
        set_pins(8'h25);
        chk("R4 bit7 diff", change_flag_o, 1);
    endtask

    task automatic t_sticky();
        do_reset();
        set_pins(8'h01);
        do_read();
        set_pins(8'h03);
        set_pins(8'h01);
        chk("R5 sticky after pins return", change_flag_o, 1);
        pin_i = 8'h03;
        cycles(4);
        do_clear();
        chk("R5 clear wins", change_flag_o, 0);
        cycles(1);
        chk("R5 re-set on persisting mismatch", change_flag_o, 1);
    endtask

    task automatic t_wake_gie_on();
        do_reset();
        set_pins(8'h5A);
        do_read();
        chg_en_i = 1; gie_i = 1; sleep_i = 1; pc_next_i = 10'h123;
        cycles(1);
        chk("R6 no wake before change", wake_req_o, 0);
        set_pins(8'h5B);
        chk("R6 wake", wake_req_o, 1);
        chk("R7 irq", irq_req_o, 1);
        chk("R7 sel", pc_sel_o, 1);
        chk("R7 next_pc", next_pc_o, 10'h3FE);
        #0.5 chg_en_i = 0;
        #0.5;
        chk("R6 wake drops without clock", wake_req_o, 0);
        chg_en_i = 1;
        #0.5;
        chk("R6 wake returns without clock", wake_req_o, 1);
    endtask

    task automatic t_wake_gie_off();
        do_reset();
        set_pins(8'hC3);
        do_read();
        chg_en_i = 1; gie_i = 0; sleep_i = 1; pc_next_i = 10'h0A7;
        set_pins(8'hC1);
        chk("R8 wake", wake_req_o, 1);
        chk("R8 irq", irq_req_o, 0);
        chk("R8 sel", pc_sel_o, 0);
        chk("R8 next_pc", next_pc_o, 10'h0A7);
    endtask

    task automatic t_disabled();
        do_reset();
        set_pins(8'h77);
        do_read();
        chg_en_i = 0; gie_i = 1; sleep_i = 1;
        set_pins(8'h76);
        chk("R9 flag records", change_flag_o, 1);
        chk("R9 no wake", wake_req_o, 0);
        chk("R9 no irq", irq_req_o, 0);
        chg_en_i = 1;
        #0.5;
        chk("R9 wake once enabled", wake_req_o, 1);
    endtask

    task automatic t_rearm();
        do_reset();
        set_pins(8'h0F);
        do_read();
        set_pins(8'hF0);
        chk("R10 first change", change_flag_o, 1);
        do_clear();
        do_read();
        cycles(4);
        chk("R10 new reference no flag", change_flag_o, 0);
        set_pins(8'h0F);
        chk("R10 old value now differs", change_flag_o, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_unarmed();
        t_latency();
        t_compare();
        t_sticky();
        t_wake_gie_on();
        t_wake_gie_off();
        t_disabled();
        t_rearm();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule